// File: doc/BRIEF.md
# Double SHA-256 Nonce Tester

This block decides whether one candidate nonce solves a proof-of-work puzzle. The header is 80 bytes long and is hashed twice with SHA-256. The first 512 bits of the header stay the same for every nonce, so software compresses them once and hands the block the resulting chaining state (the midstate). The block keeps that midstate and three per-block words: the tail word of the merkle root, the time word and the difficulty-bits word. For each test it builds the second header chunk from those words and the nonce, then adds the SHA-256 padding. It compresses that chunk starting from the midstate and then hashes the 256-bit digest a second time, starting from the standard initial values. Finally it compares the result with a 256-bit target.

A single round engine with a 16-word rolling message schedule runs both passes back to back, at one round per clock. One test therefore takes 128 cycles. Each instance carries a preset nonce offset, which is added to the broadcast nonce. Several copies can then share one nonce bus and still each hash a different value.

Top module: `dsha_nonce_tester`

## Requirements
- R1: While reset is applied, and after it is released, `busy`, `done` and `match` are 0 and `hash_out` is all zeros.
- R2: A `blk_load` pulse taken while idle stores `midstate_in`, `merkle_tail`, `time_word` and `bits_word`. Later tests reuse these stored values without another load.
- R3: The nonce that is hashed equals `nonce_in + NONCE_OFFSET` modulo 2^32. It is captured at launch and shown on `nonce_used` from the cycle after launch.
- R4: The first pass starts from the stored midstate. Its 16 big-endian message words, in order, are: merkle tail, time, bits, effective nonce, 0x80000000, ten zero words, and 0x00000280 (640).
- R5: The second pass starts from the standard SHA-256 initial values. Its message is the eight first-pass digest words, then 0x80000000, six zero words and 0x00000100 (256). `hash_out` carries the result with hash word 0 in bits 255:224.
- R6: A launch happens on a clock edge where `start` is 1, `blk_load` is 0 and `busy` is 0. From that edge, `busy` is 1 for 128 cycles. `done` is a single-cycle pulse that appears 128 edges after the launch edge, and `busy` is 0 while `done` is 1.
- R7: When `done` is 1, `match` is 1 exactly when `hash_out`, read as a 256-bit unsigned number, is less than or equal to `target` as it was sampled on the final edge.
- R8: While `busy` is 1, `start` and `blk_load` are ignored. The running test and the stored block fields are not affected.
- R9: When `start` and `blk_load` are both 1 on the same idle edge, only the load takes effect. No test starts.
- R10: `hash_out` and `match` keep their values until the next `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_load | input | 1 | Store the per-block fields (taken only while idle) |
| midstate_in | input | 256 | Chaining state after the first 512 header bits, word 0 in bits 255:224 |
| merkle_tail | input | 32 | Last 32 bits of the merkle root |
| time_word | input | 32 | Header time word |
| bits_word | input | 32 | Header difficulty-bits word |
| start | input | 1 | Launch a test of `nonce_in` |
| nonce_in | input | 32 | Broadcast nonce |
| target | input | 256 | Threshold for the comparison |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| match | output | 1 | Final hash is less than or equal to the target |
| hash_out | output | 256 | Final double hash |
| nonce_used | output | 32 | Effective nonce of the latest test |

## Verification
The bench builds the block with `NONCE_OFFSET` set to 0xFFFFFFF0. With that value, a broadcast nonce of 0x20 wraps past 2^32 to 0x10, and the offset addition is seen at both its carry and its wrap. The expected digests come from a separate compression model in the bench, which works from a midstate it derives itself. Targets equal to the hash, one below it, zero and all ones cover both sides of the less-or-equal boundary. Mid-run pokes and a joint start-and-load edge test the rules for ignored control inputs.

// File: rtl/dsha_pkg.sv
package dsha_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 8;
  localparam int BLOCK_WORDS = 16;
  localparam int ROUNDS      = 64;
  localparam int CNT_W       = $clog2(ROUNDS);
  localparam int STATE_W     = STATE_WORDS * WORD_W;
  localparam int BLOCK_W     = BLOCK_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t PAD_ONE  = 32'h8000_0000;
  localparam word_t LEN_HDR  = 32'd640;
  localparam word_t LEN_DIG  = 32'd256;

  localparam logic [STATE_W-1:0] IV_ALL = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [ROUNDS*WORD_W-1:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t k_word(input logic [CNT_W-1:0] t);
    return K_TAB[(ROUNDS-1-int'(t))*WORD_W +: WORD_W];
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t f_major(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/dsha_sched.sv
module dsha_sched
  import dsha_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BLOCK_W-1:0] load_blk,
  input  logic               adv,
  output word_t              w_cur
);
  word_t w_q [BLOCK_WORDS];
  word_t w_d [BLOCK_WORDS];
  word_t w_new;

  // Rolling window: slot 0 holds W[t]; the word fed in is W[t+16].
  always_comb begin
    w_new = sml_s1(w_q[BLOCK_WORDS-2]) + w_q[BLOCK_WORDS-7]
          + sml_s0(w_q[1]) + w_q[0];
    for (int i = 0; i < BLOCK_WORDS; i++) begin
      w_d[i] = w_q[i];
    end
    if (load) begin
      for (int i = 0; i < BLOCK_WORDS; i++) begin
        w_d[i] = load_blk[(BLOCK_WORDS-1-i)*WORD_W +: WORD_W];
      end
    end else if (adv) begin
      for (int i = 0; i < BLOCK_WORDS-1; i++) begin
        w_d[i] = w_q[i+1];
      end
      w_d[BLOCK_WORDS-1] = w_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCK_WORDS; i++) begin
        w_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < BLOCK_WORDS; i++) begin
        w_q[i] <= w_d[i];
      end
    end
  end

  assign w_cur = w_q[0];
endmodule

// File: rtl/dsha_rounds.sv
module dsha_rounds
  import dsha_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STATE_W-1:0] load_iv,
  input  logic               step,
  input  word_t              k_in,
  input  word_t              w_in,
  output logic [STATE_W-1:0] digest
);
  word_t v_q [STATE_WORDS];
  word_t v_d [STATE_WORDS];
  word_t c_q [STATE_WORDS];
  word_t c_d [STATE_WORDS];
  word_t v_rnd [STATE_WORDS];
  word_t t1, t2;

  always_comb begin
    t1 = v_q[7] + big_s1(v_q[4]) + f_choose(v_q[4], v_q[5], v_q[6]) + k_in + w_in;
    t2 = big_s0(v_q[0]) + f_major(v_q[0], v_q[1], v_q[2]);
    v_rnd[0] = t1 + t2;
    v_rnd[1] = v_q[0];
    v_rnd[2] = v_q[1];
    v_rnd[3] = v_q[2];
    v_rnd[4] = v_q[3] + t1;
    v_rnd[5] = v_q[4];
    v_rnd[6] = v_q[5];
    v_rnd[7] = v_q[6];
    for (int i = 0; i < STATE_WORDS; i++) begin
      digest[(STATE_WORDS-1-i)*WORD_W +: WORD_W] = c_q[i] + v_rnd[i];
      if (load) begin
        v_d[i] = load_iv[(STATE_WORDS-1-i)*WORD_W +: WORD_W];
        c_d[i] = load_iv[(STATE_WORDS-1-i)*WORD_W +: WORD_W];
      end else begin
        v_d[i] = step ? v_rnd[i] : v_q[i];
        c_d[i] = c_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        v_q[i] <= '0;
        c_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        v_q[i] <= v_d[i];
        c_q[i] <= c_d[i];
      end
    end
  end
endmodule

// File: rtl/dsha_ctrl.sv
module dsha_ctrl
  import dsha_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             blk_load,
  output logic             launch,
  output logic             turn,
  output logic             fin,
  output logic             busy,
  output logic [CNT_W-1:0] rnd
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DIG} phase_t;

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign busy   = (ph_q != S_IDLE);
  assign last   = (cnt_q == CNT_W'(ROUNDS-1));
  assign launch = (ph_q == S_IDLE) && start && !blk_load;
  assign turn   = (ph_q == S_HDR) && last;
  assign fin    = (ph_q == S_DIG) && last;
  assign rnd    = cnt_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      S_IDLE: begin
        if (launch) begin
          ph_d  = S_HDR;
          cnt_d = '0;
        end
      end
      S_HDR: begin
        cnt_d = last ? '0 : cnt_q + 1'b1;
        if (last) ph_d = S_DIG;
      end
      S_DIG: begin
        cnt_d = last ? '0 : cnt_q + 1'b1;
        if (last) ph_d = S_IDLE;
      end
      default: ph_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dsha_nonce_tester.sv
module dsha_nonce_tester
  import dsha_pkg::*;
#(
  parameter logic [WORD_W-1:0] NONCE_OFFSET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_load,
  input  logic [STATE_W-1:0] midstate_in,
  input  logic [WORD_W-1:0]  merkle_tail,
  input  logic [WORD_W-1:0]  time_word,
  input  logic [WORD_W-1:0]  bits_word,
  input  logic               start,
  input  logic [WORD_W-1:0]  nonce_in,
  input  logic [STATE_W-1:0] target,
  output logic               busy,
  output logic               done,
  output logic               match,
  output logic [STATE_W-1:0] hash_out,
  output logic [WORD_W-1:0]  nonce_used
);
  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic             launch, turn, fin;
  logic [CNT_W-1:0] rnd;
  word_t            w_cur;
  logic [STATE_W-1:0] digest;

  // Per-block field registers.
  logic [STATE_W-1:0] mid_q, mid_d;
  word_t mtail_q, mtail_d, time_q, time_d, bits_q, bits_d;
  word_t nonce_q, nonce_d, nonce_eff;
  logic  fld_en;

  // Result registers.
  logic [STATE_W-1:0] hash_q, hash_d;
  logic match_q, match_d, done_q, done_d;

  logic [BLOCK_W-1:0] blk_hdr, blk_dig, blk_sel;
  logic [STATE_W-1:0] iv_sel;
  logic               eng_load;

  assign nonce_eff = nonce_in + NONCE_OFFSET;
  assign fld_en    = blk_load && !busy;

  assign blk_hdr = {mtail_q, time_q, bits_q, nonce_eff, PAD_ONE,
                    {10{32'h0}}, LEN_HDR};
  assign blk_dig = {digest, PAD_ONE, {6{32'h0}}, LEN_DIG};

  assign eng_load = launch || turn;
  assign blk_sel  = launch ? blk_hdr : blk_dig;
  assign iv_sel   = launch ? mid_q : IV_ALL;

  dsha_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .blk_load (blk_load),
    .launch   (launch),
    .turn     (turn),
    .fin      (fin),
    .busy     (busy),
    .rnd      (rnd)
  );

  dsha_sched u_sched (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (eng_load),
    .load_blk (blk_sel),
    .adv      (busy),
    .w_cur    (w_cur)
  );

  dsha_rounds u_rounds (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (eng_load),
    .load_iv (iv_sel),
    .step    (busy),
    .k_in    (k_word(rnd)),
    .w_in    (w_cur),
    .digest  (digest)
  );

  always_comb begin
    mid_d   = fld_en ? midstate_in : mid_q;
    mtail_d = fld_en ? merkle_tail : mtail_q;
    time_d  = fld_en ? time_word   : time_q;
    bits_d  = fld_en ? bits_word   : bits_q;
    nonce_d = launch ? nonce_eff   : nonce_q;
    hash_d  = fin ? digest : hash_q;
    match_d = fin ? (digest <= target) : match_q;
    done_d  = fin;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mid_q   <= '0;
      mtail_q <= '0;
      time_q  <= '0;
      bits_q  <= '0;
      nonce_q <= '0;
      hash_q  <= '0;
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      mid_q   <= mid_d;
      mtail_q <= mtail_d;
      time_q  <= time_d;
      bits_q  <= bits_d;
      nonce_q <= nonce_d;
      hash_q  <= hash_d;
      match_q <= match_d;
      done_q  <= done_d;
    end
  end

  assign done       = done_q;
  assign match      = match_q;
  assign hash_out   = hash_q;
  assign nonce_used = nonce_q;
endmodule

// File: rtl/dsha_nonce_tester_chk.sv
module dsha_nonce_tester_chk
  import dsha_pkg::*;
#(
  parameter logic [WORD_W-1:0] NONCE_OFFSET = '0
) (
  input logic               clk,
  input logic               srst_n,
  input logic               start,
  input logic               blk_load,
  input logic [WORD_W-1:0]  nonce_in,
  input logic [STATE_W-1:0] target,
  input logic               busy,
  input logic               done,
  input logic               match,
  input logic [STATE_W-1:0] hash_out,
  input logic [WORD_W-1:0]  nonce_used,
  input logic [STATE_W-1:0] mid_q,
  input logic [WORD_W-1:0]  mtail_q,
  input logic [WORD_W-1:0]  time_q,
  input logic [WORD_W-1:0]  bits_q
);
  localparam int TEST_CYC = 2 * ROUNDS;
  localparam int LAT_W    = $clog2(TEST_CYC + 2);

  logic [LAT_W-1:0] lat_q;
  logic             go;

  assign go = start && !blk_load && !busy;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   lat_q <= '0;
    else if (go)   lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  p_launch_r6: assert property (@(posedge clk) disable iff (!srst_n)
    go |=> busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> !busy);

  p_done_latency_r6: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> lat_q == LAT_W'(TEST_CYC));

  p_nonce_sum_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> nonce_used == $past(nonce_in) + NONCE_OFFSET);

  p_match_cmp_r7: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> match == (hash_out <= $past(target)));

  p_fields_frozen_r8: assert property (@(posedge clk) disable iff (!srst_n)
    busy |=> $stable(mid_q) && $stable(mtail_q) && $stable(time_q) && $stable(bits_q));

  p_joint_no_launch_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (start && blk_load && !busy) |=> !busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !done |-> $stable(hash_out) && $stable(match));
endmodule

bind dsha_nonce_tester dsha_nonce_tester_chk #(.NONCE_OFFSET(NONCE_OFFSET)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .start      (start),
  .blk_load   (blk_load),
  .nonce_in   (nonce_in),
  .target     (target),
  .busy       (busy),
  .done       (done),
  .match      (match),
  .hash_out   (hash_out),
  .nonce_used (nonce_used),
  .mid_q      (mid_q),
  .mtail_q    (mtail_q),
  .time_q     (time_q),
  .bits_q     (bits_q)
);

// File: tb/dsha_nonce_tester_test.sv
`timescale 1ns/1ps
module dsha_nonce_tester_test;
  localparam logic [31:0] OFFSET = 32'hFFFF_FFF0;
  localparam logic [255:0] H_START = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  logic [31:0] kc [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  logic clk = 1'b0;
  logic rst_n, blk_load, start;
  logic [255:0] midstate_in, target;
  logic [31:0]  merkle_tail, time_word, bits_word, nonce_in;
  logic busy, done, match;
  logic [255:0] hash_out;
  logic [31:0]  nonce_used;

  int total = 0;
  int bad   = 0;

  // Fields the design should currently hold, tracked from accepted loads.
  logic [255:0] ref_mid;
  logic [31:0]  ref_mt, ref_tm, ref_bt;

  always #2.5 clk = ~clk;

  dsha_nonce_tester #(.NONCE_OFFSET(OFFSET)) uut (
    .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .midstate_in(midstate_in),
    .merkle_tail(merkle_tail), .time_word(time_word), .bits_word(bits_word),
    .start(start), .nonce_in(nonce_in), .target(target), .busy(busy),
    .done(done), .match(match), .hash_out(hash_out), .nonce_used(nonce_used));

  // ---------------- reference model ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] st, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2, s0, s1;
    logic [255:0] res;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 64; i++) begin
      s0 = rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3);
      s1 = rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10);
      w[i] = w[i-16] + s0 + w[i-7] + s1;
    end
    for (int i = 0; i < 8; i++) v[i] = st[255-32*i -: 32];
    for (int i = 0; i < 64; i++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kc[i] + w[i];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = st[255-32*i -: 32] + v[i];
    return res;
  endfunction

  function automatic logic [255:0] dbl_hash(input logic [31:0] eff);
    logic [255:0] first;
    first = compress(ref_mid, {ref_mt, ref_tm, ref_bt, eff, 32'h8000_0000, 320'h0, 32'd640});
    return compress(H_START, {first, 32'h8000_0000, 192'h0, 32'd256});
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic load_fields(input logic [255:0] m, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input bit with_start);
    @(negedge clk);
    midstate_in = m; merkle_tail = a; time_word = b; bits_word = c;
    blk_load = 1'b1; start = with_start;
    @(negedge clk);
    blk_load = 1'b0; start = 1'b0;
    ref_mid = m; ref_mt = a; ref_tm = b; ref_bt = c;
  endtask

  // Launch one test, check timing, nonce, hash and match. poke injects
  // start and blk_load in the middle of the run.
  task automatic run_nonce(input logic [31:0] n, input logic [255:0] tgt,
                           input logic [255:0] exp_h, input bit poke);
    logic [31:0] eff;
    bit early;
    eff = n + OFFSET;
    early = 1'b0;
    @(negedge clk);
    nonce_in = n; target = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6 busy after launch", 256'(busy), 256'd1);
    chk(nonce_used == eff, "R3 effective nonce", 256'(nonce_used), 256'(eff));
    for (int c = 1; c < 128; c++) begin
      if (poke && c == 50) begin
        start = 1'b1; blk_load = 1'b1; nonce_in = n ^ 32'h5;
        midstate_in = ~ref_mid; merkle_tail = ~ref_mt;
      end
      @(negedge clk);
      if (poke && c == 50) begin
        start = 1'b0; blk_load = 1'b0;
      end
      if (done || !busy) early = 1'b1;
    end
    chk(!early, "R6 busy held and no early done", 256'(early), 256'd0);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R6 done at cycle 128", 256'({done, busy}), 256'b10);
    chk(hash_out == exp_h, "R4/R5 double hash", hash_out, exp_h);
    chk(match == (exp_h <= tgt), "R7 target compare", 256'(match), 256'(exp_h <= tgt));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", 256'(done), 256'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0 && done == 0 && match == 0, "R1 flags after reset",
        256'({busy, done, match}), 256'd0);
    chk(hash_out == '0, "R1 hash after reset", hash_out, 256'd0);
  endtask

  task automatic t_basic();
    logic [511:0] hdr0;
    logic [255:0] m;
    for (int i = 0; i < 16; i++) hdr0[511-32*i -: 32] = (32'h9e3779b9 * (i + 1)) ^ (32'h0100_0000 * i);
    m = compress(H_START, hdr0);
    load_fields(m, 32'h4a5e1e4b, 32'h495fab29, 32'h1d00ffff, 1'b0);
    run_nonce(32'h0000_0000, {256{1'b1}}, dbl_hash(32'h0 + OFFSET), 1'b0);
  endtask

  task automatic t_keep_fields();
    // R2: no reload, a new nonce, fields reused; target zero gives no match.
    run_nonce(32'h0001_2345, 256'd0, dbl_hash(32'h0001_2345 + OFFSET), 1'b0);
  endtask

  task automatic t_wrap();
    // R3: 0x20 + 0xFFFFFFF0 wraps to 0x10.
    run_nonce(32'h0000_0020, {256{1'b1}}, dbl_hash(32'h0000_0010), 1'b0);
    chk(nonce_used == 32'h10, "R3 wrapped nonce held", 256'(nonce_used), 256'h10);
  endtask

  task automatic t_target_edges();
    logic [255:0] h;
    h = dbl_hash(32'h0000_0777 + OFFSET);
    run_nonce(32'h0000_0777, h, h, 1'b0);          // R7 equal -> match
    run_nonce(32'h0000_0777, h - 1'b1, h, 1'b0);   // R7 one below -> no match
  endtask

  task automatic t_busy_ignore();
    logic [255:0] h;
    h = dbl_hash(32'h0bad_cafe + OFFSET);
    run_nonce(32'h0bad_cafe, {256{1'b1}}, h, 1'b1);  // R8 pokes ignored
    run_nonce(32'h0000_0042, {256{1'b1}}, dbl_hash(32'h0000_0042 + OFFSET), 1'b0); // R8 fields kept
  endtask

  task automatic t_hold();
    logic [255:0] h;
    logic m;
    h = hash_out; m = match;
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk(hash_out == h && match == m, "R10 result held while idle", hash_out, h);
    @(negedge clk);
    nonce_in = 32'h55; target = 256'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60; i++) @(negedge clk);
    chk(hash_out == h && match == m, "R10 result held during next test", hash_out, h);
    for (int i = 0; i < 80; i++) @(negedge clk);
  endtask

  task automatic t_joint();
    bit seen;
    seen = 1'b0;
    load_fields(256'h0123_4567_89ab_cdef_fedc_ba98_7654_3210_0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0,
                32'hdead_beef, 32'h6000_0001, 32'h1703_a30c, 1'b1);
    chk(busy == 1'b0, "R9 joint start and load does not launch", 256'(busy), 256'd0);
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (done || busy) seen = 1'b1;
    end
    chk(!seen, "R9 no test after joint edge", 256'(seen), 256'd0);
    run_nonce(32'h0000_0007, {256{1'b1}}, dbl_hash(32'h0000_0007 + OFFSET), 1'b0); // R2 new fields
  endtask

  initial begin
    rst_n = 1'b0; blk_load = 1'b0; start = 1'b0;
    midstate_in = '0; merkle_tail = '0; time_word = '0; bits_word = '0;
    nonce_in = '0; target = '0;
    ref_mid = '0; ref_mt = '0; ref_tm = '0; ref_bt = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_keep_fields();
    t_wrap();
    t_target_edges();
    t_busy_ignore();
    t_hold();
    t_joint();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200us;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule